// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block is a tag-only directory of a set-associative data cache, used to model cache behaviour for performance studies. It takes one request at a time: a 32-bit byte address and a 2-bit operation (load, store, swap or no-op). For each request it answers whether the access hit, and how many stall cycles that access costs. No data is held and no refill or write-back traffic is produced. Only the line addresses that would be resident are tracked.

Each way of a set holds the full line address of the line it caches, or an invalid marker. A load miss installs its line in a victim way. A store miss changes nothing. Two victim policies exist. The random policy uses a single way pointer shared by all sets, and that pointer takes one extra step on every thirteenth allocation. The round-robin policy gives every set its own pointer. The policy comes from a parameter, or from a pin sampled during reset. Four 64-bit event counters show load and store hits and misses.

Top module: `tag_directory`

## Requirements
- R1: During reset and after it, every tag entry is invalid, so the first access to any address misses. All four counters read zero, `req_ready` is high and `resp_valid` is low.
- R2: The line address is `req_addr >> log2(LINE_BYTES)`, with sizes rounded up to powers of two. The set index is the low bits of the line address, which are address bits [11:5] by default. A request hits only when a way of that set holds the whole line address. Two addresses in the same line share an entry. Lines in the same set that differ only in their upper bits never alias, including the line at 0xFFFFFFE0.
- R3: A load (opcode 0) that misses writes its line address into the victim way and reports a stall of LOAD_PENALTY (30 by default). A load that hits reports stall 0.
- R4: A store (opcode 1) that misses reports a stall of STORE_PENALTY (5 by default) and writes no tag, so a later load to that line still misses. A store that hits reports stall 0.
- R5: A swap (opcode 2) acts as a load followed by a store to the same address. The response hit is the load's result and the stall is the sum of both parts. The store part always hits, so a swap adds one load event and one store hit.
- R6: In random mode one global way pointer supplies every victim and advances by one (modulo the way count) after each allocation. On every thirteenth allocation it advances by one further step.
- R7: In round-robin mode each set has its own victim pointer. The pointer starts at way 0 and advances by one, modulo the way count, after each allocation in that set.
- R8: The four 64-bit counters (load hit, load miss, store hit, store miss) each count the events of their kind and clear only on reset.
- R9: `req_ready` is high only while no request is in flight. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `resp_valid` is high for exactly one cycle: 2 cycles after acceptance for a load or store, 3 for a swap and 1 for a no-op. `req_ready` returns in the cycle after the response.
- R10: A no-op (opcode 3) reports hit 0 and stall 0, changes no counter, and neither writes a tag nor moves a victim pointer.
- R11: With PIN_POLICY set (the default), `cfg_round_robin` is sampled while `rst_n` is low. A value of 1 selects round-robin and 0 selects random. With PIN_POLICY clear, the ROUND_ROBIN parameter decides the policy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_round_robin | input | 1 | Policy select, sampled during reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Directory idle, request can be taken |
| req_addr | input | 32 | Byte address |
| req_op | input | 2 | 0 load, 1 store, 2 swap, 3 no-op |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Access hit (load part for a swap) |
| resp_stall | output | STALL_W | Stall cycles charged to the access |
| cnt_load_hit | output | 64 | Load hits |
| cnt_load_miss | output | 64 | Load misses |
| cnt_store_hit | output | 64 | Store hits |
| cnt_store_miss | output | 64 | Store misses |

## Verification
Two actions share one clock edge. When a load misses, the tag write, the victim pointer step and the load-miss count all happen on the same edge. In a swap, the store part then looks up the entry that was written on the edge just before. Swaps to lines that are not resident provoke this case, both directed and mixed into a random stream that crowds six lines into each of a few sets. The bench judges it from the response hit and stall, the store-hit counter, and whether later loads hit in the way the reference model predicts for the active policy.

// File: rtl/tag_directory_pkg.sv
package tag_directory_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'd0,
        OP_STORE = 2'd1,
        OP_SWAP  = 2'd2,
        OP_NOP   = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_STORE = 2'd2,
        PH_RESP  = 2'd3
    } phase_e;

    // event vector bit positions
    localparam int EV_LD_HIT  = 0;
    localparam int EV_LD_MISS = 1;
    localparam int EV_ST_HIT  = 2;
    localparam int EV_ST_MISS = 3;

endpackage

// File: rtl/tag_directory_array.sv
module tag_directory_array #(
    parameter int SETS  = 128,
    parameter int WAYS  = 4,
    parameter int TAG_W = 28,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_idx,
    input  logic [TAG_W-1:0] look_tag,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    output logic [WAYS-1:0]  hit_vec
);

    localparam logic [TAG_W-1:0] INVALID = '1;

    logic [TAG_W-1:0] tags_q [SETS][WAYS];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    tags_q[s][w] <= INVALID;
                end
            end
        end else if (wr_en) begin
            tags_q[set_idx][wr_way] <= look_tag;
        end
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign hit_vec[w] = (tags_q[set_idx][w] == look_tag);
    end

    // R2: a line is resident in at most one way of its set
    a_r2_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

endmodule

// File: rtl/tag_directory_victim.sv
module tag_directory_victim #(
    parameter int SETS   = 128,
    parameter int WAYS   = 4,
    parameter int PERIOD = 13,
    localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
    localparam int CNT_W = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rr_mode,
    input  logic             alloc,
    input  logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] victim
);

    typedef struct packed {
        logic [WAY_W-1:0] ptr;
        logic [CNT_W-1:0] cnt;
    } rnd_t;

    rnd_t rnd_d, rnd_q;
    logic [WAY_W-1:0] rr_q [SETS];

    always_comb begin
        rnd_d = rnd_q;
        if (alloc && !rr_mode) begin
            if (rnd_q.cnt == CNT_W'(PERIOD - 1)) begin
                rnd_d.cnt = '0;
                rnd_d.ptr = rnd_q.ptr + WAY_W'(2);
            end else begin
                rnd_d.cnt = rnd_q.cnt + CNT_W'(1);
                rnd_d.ptr = rnd_q.ptr + WAY_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rnd_q <= '0;
        else        rnd_q <= rnd_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) rr_q[s] <= '0;
        end else if (alloc && rr_mode) begin
            rr_q[set_idx] <= rr_q[set_idx] + WAY_W'(1);
        end
    end

    assign victim = rr_mode ? rr_q[set_idx] : rnd_q.ptr;

    // R6: replacement counter stays inside its period
    a_r6_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_q.cnt < CNT_W'(PERIOD));

    // R6: the period-closing allocation moves the shared pointer two steps
    a_r6_extra_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && !rr_mode && rnd_q.cnt == CNT_W'(PERIOD - 1))
        |=> (victim == $past(victim) + WAY_W'(2)) || rr_mode);

    // R7: in round-robin mode the set's pointer moves one past its victim
    a_r7_rr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc && rr_mode) |=> rr_q[$past(set_idx)] == $past(victim) + WAY_W'(1));

endmodule

// File: rtl/tag_directory_counters.sv
module tag_directory_counters #(
    parameter int CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       ev,
    output logic [CNT_W-1:0] cnt [4]
);

    logic [CNT_W-1:0] cnt_d [4];
    logic [CNT_W-1:0] cnt_q [4];

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            cnt_d[i] = cnt_q[i] + (ev[i] ? CNT_W'(1) : CNT_W'(0));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) cnt_q[i] <= '0;
        end else begin
            for (int i = 0; i < 4; i++) cnt_q[i] <= cnt_d[i];
        end
    end

    assign cnt = cnt_q;

    // R8: one event kind per cycle at most
    a_r8_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ev));

endmodule

// File: rtl/tag_directory.sv
module tag_directory
    import tag_directory_pkg::*;
#(
    parameter int CACHE_BYTES   = 16384,
    parameter int WAYS          = 4,
    parameter int LINE_BYTES    = 32,
    parameter int LOAD_PENALTY  = 30,
    parameter int STORE_PENALTY = 5,
    parameter int REPL_PERIOD   = 13,
    parameter int STALL_W       = 16,
    parameter bit PIN_POLICY    = 1'b1,
    parameter bit ROUND_ROBIN   = 1'b0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_round_robin,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [31:0]        req_addr,
    input  logic [1:0]         req_op,
    output logic               resp_valid,
    output logic               resp_hit,
    output logic [STALL_W-1:0] resp_stall,
    output logic [63:0]        cnt_load_hit,
    output logic [63:0]        cnt_load_miss,
    output logic [63:0]        cnt_store_hit,
    output logic [63:0]        cnt_store_miss
);

    localparam int OFF_W   = $clog2(LINE_BYTES);
    localparam int WAY_LG  = $clog2(WAYS);
    localparam int WAYS_P2 = 1 << WAY_LG;
    localparam int SET_LG  = $clog2(CACHE_BYTES) - OFF_W - WAY_LG;
    localparam int SETS    = 1 << SET_LG;
    localparam int SET_W   = (SETS > 1) ? SET_LG : 1;
    localparam int WAY_W   = (WAYS_P2 > 1) ? WAY_LG : 1;
    localparam int LINE_W  = 32 - OFF_W;
    localparam int TAG_W   = LINE_W + 1;

    typedef struct packed {
        phase_e             ph;
        logic [31:0]        addr;
        op_e                op;
        logic               hit;
        logic [STALL_W-1:0] stall;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic               rr_mode;
    logic [TAG_W-1:0]   line_tag;
    logic [SET_W-1:0]   set_idx;
    logic [WAYS_P2-1:0] hit_vec;
    logic               hit_any;
    logic               alloc;
    logic [WAY_W-1:0]   victim;
    logic [3:0]         ev;
    logic [63:0]        cnt [4];

    // policy selection variant
    if (PIN_POLICY) begin : g_pin_policy
        logic rr_q;
        always_ff @(posedge clk) begin
            if (!rst_n) rr_q <= cfg_round_robin;
        end
        assign rr_mode = rr_q;
    end else begin : g_fixed_policy
        assign rr_mode = ROUND_ROBIN;
    end

    // zero-extended line address; the all-ones invalid code cannot match it
    assign line_tag = {1'b0, ctl_q.addr[31:OFF_W]};
    if (SETS > 1) begin : g_idx
        assign set_idx = ctl_q.addr[OFF_W +: SET_W];
    end else begin : g_idx1
        assign set_idx = '0;
    end

    assign hit_any = |hit_vec;
    assign alloc   = (ctl_q.ph == PH_LOAD) && !hit_any;

    always_comb begin
        ctl_d = ctl_q;
        ev    = '0;
        unique case (ctl_q.ph)
            PH_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr  = req_addr;
                    ctl_d.op    = op_e'(req_op);
                    ctl_d.hit   = 1'b0;
                    ctl_d.stall = '0;
                    unique case (op_e'(req_op))
                        OP_STORE: ctl_d.ph = PH_STORE;
                        OP_NOP:   ctl_d.ph = PH_RESP;
                        default:  ctl_d.ph = PH_LOAD;
                    endcase
                end
            end
            PH_LOAD: begin
                ctl_d.hit   = hit_any;
                ctl_d.stall = hit_any ? '0 : STALL_W'(LOAD_PENALTY);
                ev[EV_LD_HIT]  = hit_any;
                ev[EV_LD_MISS] = !hit_any;
                ctl_d.ph = (ctl_q.op == OP_SWAP) ? PH_STORE : PH_RESP;
            end
            PH_STORE: begin
                if (ctl_q.op == OP_STORE) ctl_d.hit = hit_any;
                if (!hit_any) ctl_d.stall = ctl_q.stall + STALL_W'(STORE_PENALTY);
                ev[EV_ST_HIT]  = hit_any;
                ev[EV_ST_MISS] = !hit_any;
                ctl_d.ph = PH_RESP;
            end
            default: begin
                ctl_d.ph = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '{ph: PH_IDLE, addr: '0, op: OP_LOAD, hit: 1'b0, stall: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    tag_directory_array #(
        .SETS (SETS),
        .WAYS (WAYS_P2),
        .TAG_W(TAG_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_idx (set_idx),
        .look_tag(line_tag),
        .wr_en   (alloc),
        .wr_way  (victim),
        .hit_vec (hit_vec)
    );

    tag_directory_victim #(
        .SETS  (SETS),
        .WAYS  (WAYS_P2),
        .PERIOD(REPL_PERIOD)
    ) u_victim (
        .clk    (clk),
        .rst_n  (rst_n),
        .rr_mode(rr_mode),
        .alloc  (alloc),
        .set_idx(set_idx),
        .victim (victim)
    );

    tag_directory_counters #(
        .CNT_W(64)
    ) u_counters (
        .clk  (clk),
        .rst_n(rst_n),
        .ev   (ev),
        .cnt  (cnt)
    );

    assign req_ready      = (ctl_q.ph == PH_IDLE);
    assign resp_valid     = (ctl_q.ph == PH_RESP);
    assign resp_hit       = ctl_q.hit;
    assign resp_stall     = ctl_q.stall;
    assign cnt_load_hit   = cnt[EV_LD_HIT];
    assign cnt_load_miss  = cnt[EV_LD_MISS];
    assign cnt_store_hit  = cnt[EV_ST_HIT];
    assign cnt_store_miss = cnt[EV_ST_MISS];

    // R9: an accepted request blocks the port until it has responded
    a_r9_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: response is a single-cycle strobe followed by an idle port
    a_r9_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> (!resp_valid && req_ready));

    // R5: the store half of a swap finds the line the load half left
    a_r5_swap_store_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.ph == PH_STORE && ctl_q.op == OP_SWAP) |-> hit_any);

    // R10: an accepted no-op raises no counter event in the following cycle
    a_r10_nop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_op == 2'd3) |=> (ev == 4'd0));

    // R3: a load miss answers with the load penalty
    a_r3_load_miss_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && ctl_q.op == OP_LOAD && !resp_hit)
        |-> resp_stall == STALL_W'(LOAD_PENALTY));

    // R4: a store hit is free
    a_r4_store_hit_free: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && ctl_q.op == OP_STORE && resp_hit) |-> resp_stall == '0);

endmodule

// File: tb/tag_directory_tb.sv
module tag_directory_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SETS = 128;
    localparam int WAYS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_round_robin = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic [1:0]  req_op = '0;
    logic        resp_valid;
    logic        resp_hit;
    logic [15:0] resp_stall;
    logic [63:0] cnt_load_hit, cnt_load_miss, cnt_store_hit, cnt_store_miss;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference model state
    logic [31:0] m_tag [SETS][WAYS];
    int          m_rr  [SETS];
    int          m_ptr, m_cnt;
    bit          m_rrmode;
    longint      m_lh, m_lm, m_sh, m_sm;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tag_directory u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_round_robin(cfg_round_robin),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_op         (req_op),
        .resp_valid     (resp_valid),
        .resp_hit       (resp_hit),
        .resp_stall     (resp_stall),
        .cnt_load_hit   (cnt_load_hit),
        .cnt_load_miss  (cnt_load_miss),
        .cnt_store_hit  (cnt_store_hit),
        .cnt_store_miss (cnt_store_miss)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic model_reset(input bit rr);
        for (int s = 0; s < SETS; s++) begin
            m_rr[s] = 0;
            for (int w = 0; w < WAYS; w++) m_tag[s][w] = 32'hFFFF_FFFF;
        end
        m_ptr = 0; m_cnt = 0; m_rrmode = rr;
        m_lh = 0; m_lm = 0; m_sh = 0; m_sm = 0;
    endtask

    function automatic bit m_find(input logic [31:0] a);
        logic [31:0] ln = a >> 5;
        int s = int'(ln[6:0]);
        for (int w = 0; w < WAYS; w++) if (m_tag[s][w] == ln) return 1'b1;
        return 1'b0;
    endfunction

    task automatic m_load(input logic [31:0] a, output bit h, output int st);
        logic [31:0] ln = a >> 5;
        int s = int'(ln[6:0]);
        int v;
        h = m_find(a);
        if (h) begin m_lh++; st = 0; end
        else begin
            m_lm++; st = 30;
            if (m_rrmode) begin
                v = m_rr[s]; m_rr[s] = (v + 1) % WAYS;
            end else begin
                v = m_ptr; m_ptr = (m_ptr + 1) % WAYS; m_cnt++;
                if (m_cnt == 13) begin m_cnt = 0; m_ptr = (m_ptr + 1) % WAYS; end
            end
            m_tag[s][v] = ln;
        end
    endtask

    task automatic m_store(input logic [31:0] a, output bit h, output int st);
        h = m_find(a);
        if (h) begin m_sh++; st = 0; end
        else   begin m_sm++; st = 5; end
    endtask

    task automatic apply_reset(input bit rr);
        @(negedge clk);
        rst_n = 1'b0; cfg_round_robin = rr; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(rr);
        // R1: state right after reset
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(resp_valid == 1'b0, "R1", "resp_valid after reset", resp_valid, 0);
        chk((cnt_load_hit | cnt_load_miss | cnt_store_hit | cnt_store_miss) == 0,
            "R1", "counters after reset",
            longint'(cnt_load_hit + cnt_load_miss + cnt_store_hit + cnt_store_miss), 0);
    endtask

    task automatic xact(input logic [1:0] op, input logic [31:0] a, input string rq);
        bit eh, h2; int es, s2, lat, elat;
        case (op)
            2'd0: begin m_load(a, eh, es); elat = 2; end
            2'd1: begin m_store(a, eh, es); elat = 2; end
            2'd2: begin m_load(a, eh, es); m_store(a, h2, s2); es += s2; elat = 3; end
            default: begin eh = 0; es = 0; elat = 1; end
        endcase
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_op = op;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        chk(req_ready == 1'b0, "R9", "ready while busy", req_ready, 0);
        while (!resp_valid && lat < 8) begin @(negedge clk); lat++; end
        chk(lat == elat, "R9", "response latency", lat, elat);
        chk(resp_hit == eh, rq, "hit", resp_hit, eh);
        chk(int'(resp_stall) == es, rq, "stall", resp_stall, es);
        @(negedge clk);
        chk(resp_valid == 1'b0 && req_ready == 1'b1, "R9", "strobe ends, port idle",
            {resp_valid, req_ready}, 1);
    endtask

    task automatic check_counters(input string rq);
        chk(cnt_load_hit   == 64'(m_lh), rq, "load hit count",   cnt_load_hit,   m_lh);
        chk(cnt_load_miss  == 64'(m_lm), rq, "load miss count",  cnt_load_miss,  m_lm);
        chk(cnt_store_hit  == 64'(m_sh), rq, "store hit count",  cnt_store_hit,  m_sh);
        chk(cnt_store_miss == 64'(m_sm), rq, "store miss count", cnt_store_miss, m_sm);
    endtask

    function automatic logic [31:0] rnd_addr();
        logic [31:0] hi  = 32'($urandom % 6);
        logic [31:0] set = 32'($urandom % 4);
        logic [31:0] off = 32'($urandom % 32);
        return (hi << 12) | (set << 5) | off;
    endfunction

    task automatic random_run(input int n, input string rq);
        for (int i = 0; i < n; i++) begin
            logic [1:0] op = 2'($urandom % 4);
            xact(op, rnd_addr(), rq);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));

        // ---------- random policy ----------
        apply_reset(1'b0);
        xact(2'd0, 32'h0000_0040, "R3");            // load miss, stall 30
        xact(2'd0, 32'h0000_005C, "R2");            // same line: hit
        xact(2'd1, 32'h1000_0000, "R4");            // store miss, stall 5
        xact(2'd0, 32'h1000_0004, "R4");            // no allocate: still misses
        xact(2'd1, 32'h1000_0008, "R4");            // now a store hit
        xact(2'd2, 32'h0000_3080, "R5");            // swap to absent line
        xact(2'd2, 32'h0000_3080, "R5");            // swap to present line
        xact(2'd3, 32'h0000_0040, "R10");           // no-op
        check_counters("R10");
        xact(2'd0, 32'h0000_0040, "R10");           // still resident after no-op
        xact(2'd0, 32'hFFFF_FFE0, "R2");            // highest line misses
        xact(2'd0, 32'hFFFF_FFFF, "R2");            // then hits
        xact(2'd0, 32'h0000_0FE0, "R2");            // same set, other line: miss
        // R6: 20 allocations into one set walk the shared pointer past a period
        for (int i = 0; i < 20; i++) xact(2'd0, 32'(i + 16) << 12 | 32'h0A0, "R6");
        for (int i = 14; i < 20; i++) xact(2'd0, 32'(i + 16) << 12 | 32'h0A0, "R6");
        random_run(700, "R6");
        check_counters("R8");

        // ---------- round-robin policy selected at reset ----------
        apply_reset(1'b1);
        xact(2'd0, 32'h0000_0020, "R11");           // other set first
        for (int i = 0; i < 5; i++) xact(2'd0, 32'(i) << 12 | 32'h120, "R7");
        xact(2'd0, 32'h0000_0120, "R7");            // line 0 evicted from way 0
        xact(2'd0, 32'h0000_1120, "R7");
        random_run(700, "R7");
        check_counters("R8");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule